// File: doc/BRIEF.md
# Serial-to-Parallel Byte Capture

This block assembles a serial bit stream into bytes. On every rising clock edge one bit moves into an eight-stage shift register. The bit taken is the logical AND of two serial inputs, so either input can act as a gate that forces zeros. A modulo-8 frame counter runs from the same clock. On the edge where that counter wraps from its last value back to zero, a separate held register takes in the whole shift register. The held register then keeps the word steady while the next eight bits arrive. Each load comes with a one-cycle valid pulse.

Byte alignment is set only by reset: the first bit after reset release starts a frame. The live shift contents are brought out for observation. There is no start-bit detection and no framing recovery.

Top module: `sp_capture`

## Requirements
- R1: While rst_n is low, shift_o, word_o and word_valid_o are all zero and the frame counter is zero; reset is asynchronous.
- R2: On each rising clock edge with rst_n high, shift_o becomes {shift_o[W-2:0], ser_a_i & ser_b_i}, with the newest bit at bit 0.
- R3: The effective serial bit is the AND of ser_a_i and ser_b_i; if either input is 0 the bit shifted in is 0.
- R4: The frame counter advances by one each clock modulo W (W=8), starting at 0 after reset.
- R5: On the edge where the counter goes from W-1 to 0, word_o loads the shift register including the bit shifted on that same edge, so word_o equals the last W bits received.
- R6: The first bit received in a frame appears at word_o[W-1] (MSB) and the last at word_o[0].
- R7: word_valid_o is high for exactly the one cycle following each load, and is low otherwise.
- R8: word_o holds its value unchanged between loads, even though shift_o changes every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_a_i | input | 1 | Serial data input A |
| ser_b_i | input | 1 | Serial data input B, ANDed with A |
| shift_o | output | W | Live shift register contents |
| word_o | output | W | Held captured word |
| word_valid_o | output | 1 | One-cycle pulse after each capture |

## Verification
The bench drives every byte value 0 to 255 as consecutive frames, MSB first, and compares each captured word and its valid pulse with the byte that was sent. If a design captured one cycle early, it would drop the last bit and repeat the previous one. A reversed bit order would show up as a mirrored byte. If the held word tracked the shift register, it would show changes in mid-frame. Frames with one serial input held low must capture zero, which catches an OR or a single-input tap. A reset asserted in mid-frame must restart alignment, which catches a counter that survives reset.

// File: rtl/sp_capture_pkg.sv
package sp_capture_pkg;
    localparam int unsigned WORD_W = 8;
endpackage

// File: rtl/sp_shift_reg.sv
module sp_shift_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sr = {st_q.sr[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.sr;

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> data_o[W-1:1] == $past(data_o[W-2:0]));
endmodule

// File: rtl/sp_frame_ctr.sv
module sp_frame_ctr #(
    parameter int unsigned W = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wrap_o = (st_q.cnt == LAST);

    // R4
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(st_q.cnt) != LAST |-> st_q.cnt == $past(st_q.cnt) + 1'b1);
    // R4
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> st_q.cnt == '0);
endmodule

// File: rtl/sp_capture.sv
module sp_capture #(
    parameter int unsigned W = sp_capture_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_a_i,
    input  logic         ser_b_i,
    output logic [W-1:0] shift_o,
    output logic [W-1:0] word_o,
    output logic         word_valid_o
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         vld;
    } st_t;

    st_t  st_d, st_q;
    logic ser_bit;
    logic wrap;

    assign ser_bit = ser_a_i & ser_b_i;

    sp_shift_reg #(.W(W)) u_sr (
        .clk(clk), .rst_n(rst_n), .bit_i(ser_bit), .data_o(shift_o)
    );

    sp_frame_ctr #(.W(W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .wrap_o(wrap)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = wrap;
        if (wrap) st_d.word = {shift_o[W-2:0], ser_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o       = st_q.word;
    assign word_valid_o = st_q.vld;

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_o));
    // R5
    word_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> word_o == shift_o);
    // R7
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);
    // R3
    gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_a_i && ser_b_i) |=> !shift_o[0]);
endmodule

// File: tb/sp_capture_bench.sv
`timescale 1ns/1ps
module sp_capture_bench;
    localparam int W = 8;
    logic clk = 0, rst_n = 0, a = 0, b = 0;
    logic [W-1:0] shift_o, word_o;
    logic vld;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sp_capture #(.W(W)) u_sp_capture (
        .clk(clk), .rst_n(rst_n), .ser_a_i(a), .ser_b_i(b),
        .shift_o(shift_o), .word_o(word_o), .word_valid_o(vld)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one frame; inputs change at negedge, sampled at next negedge
    task automatic send(input logic [W-1:0] v, input bit gate_b, input logic [W-1:0] prev);
        for (int i = W-1; i >= 0; i--) begin
            a = v[i]; b = gate_b ? 1'b0 : 1'b1;
            @(negedge clk);
            // R2 / R3: newest bit at LSB
            chk(shift_o[0] == (gate_b ? 1'b0 : v[i]), "R2_R3", shift_o[0], gate_b ? 0 : v[i]);
            if (i != 0) begin
                // R8 / R7: held word and no pulse mid-frame
                chk(word_o == prev && !vld, "R8", word_o, prev);
            end
        end
        // R5 / R6 / R7: captured, MSB first, pulse
        chk(word_o == (gate_b ? '0 : v), "R5_R6", word_o, gate_b ? 0 : v);
        chk(vld == 1'b1, "R7", vld, 1);
    endtask

    initial begin
        logic [W-1:0] prev;
        @(negedge clk); @(negedge clk);
        // R1
        chk(shift_o == 0 && word_o == 0 && vld == 0, "R1", word_o, 0);
        rst_n = 1;
        prev = '0;
        for (int v = 0; v < 256; v++) begin
            send(W'(v), 1'b0, prev);
            prev = W'(v);
        end
        // R3: B gates a pattern of ones to zero
        send(8'hFF, 1'b1, prev); prev = '0;
        send(8'hA5, 1'b0, prev); prev = 8'hA5;
        // mid-frame reset restarts alignment (R1, R4)
        a = 1; b = 1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 0;
        #1;
        chk(shift_o == 0 && word_o == 0 && vld == 0, "R1", word_o, 0);
        @(negedge clk); rst_n = 1;
        send(8'h3C, 1'b0, 8'h00);
        send(8'hC3, 1'b0, 8'h3C);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule